// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the slave side of a four-wire serial link in front of a small byte-addressed memory model. A host lowers the select line, clocks an 8-bit command in on the data-in line, and may follow it with a 16-bit address and data bytes. The front end runs in one system clock domain. It synchronises the serial clock, select, pause, protect and data-in lines, detects their edges, samples data on rising serial clock edges and changes its output after falling edges. The output drive is reported on a separate enable so that a pad or bus model can tri-state the line.

Besides array reads and writes, it has a status byte with a busy flag, a write-enable latch, two user bits and a protect-enable bit. It accepts commands that set and clear the latch, and commands that read and write the status byte. A pause input freezes a transfer part-way and keeps its position. A protect pin can veto status writes, but only while protect-enable is set. Writes land only when select rises cleanly after a whole byte. Each write then holds the busy flag for a fixed number of system clocks.

Top module: `spi_mem_slave`

## Requirements
- R1: Bits travel most significant first on both data lines. Data in is sampled on rising serial clock edges. Data out changes only after falling edges and is valid before the next rising edge.
- R2: While select is high, the output enable is 0 and serial clock and data-in activity has no effect. Each fall of select restarts command capture.
- R3: The command codes are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. The last two are followed by a 16-bit address, high byte first.
- R4: Read status returns a byte with the busy flag in bit 0, the write-enable latch in bit 1, user bits in bits 3:2 and protect-enable in bit 7. Other bits are 0. The byte repeats for as long as the host keeps clocking.
- R5: Read array returns the byte at the address modulo DEPTH. It then moves to the next address for each further byte and wraps from DEPTH-1 to 0.
- R6: Write array data goes into a PAGE-byte buffer, and the address wraps within its page. The data reaches the array only when select rises with no partial byte pending, at least one data byte taken, and the latch set. Otherwise the data is dropped and the latch is left as it was.
- R7: Each committed write clears the latch and holds the busy flag for BUSY_CYCLES system clocks. While busy, every command except read status is rejected.
- R8: An unknown or rejected command leaves the output enable at 0 and ignores all later bytes until select falls again.
- R9: A fall of the pause input while serial clock is low freezes the transfer. While frozen, the output enable is 0 and clock and data-in are ignored. A rise while serial clock is low resumes at the same bit position.
- R10: A status write is refused when the protect pin is low and protect-enable is 1. When protect-enable is 0 the pin is ignored.
- R11: If the protect pin goes low while a status write is selected and protect-enable is 1, that write is dropped, even if the pin returns high before select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Active-low transfer pause |
| prot_n | input | 1 | Active-low status write protect pin |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
The bench builds the block with a 64-byte array, 8-byte pages, a two-stage synchroniser and a busy time of 600 clocks. With that busy time, a status read and a rejected array read both fit inside the busy window, so the busy flag and command rejection can be observed. The small page makes in-page address wrap reachable with three bytes, and the small array makes the read wrap from the last address to 0 reachable. Each serial half period lasts eight system clocks, which leaves room after every edge for the synchroniser and output register latency.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_WR_DISABLE = 8'h04;
    localparam logic [7:0] OP_STAT_READ  = 8'h05;
    localparam logic [7:0] OP_STAT_WRITE = 8'h01;
    localparam logic [7:0] OP_READ       = 8'h03;
    localparam logic [7:0] OP_WRITE      = 8'h02;

    // bit positions of the synchronised input vector
    localparam int SI_DATA  = 0;
    localparam int SI_CLK   = 1;
    localparam int SI_SEL   = 2;
    localparam int SI_PROT  = 3;
    localparam int SI_PAUSE = 4;
    localparam int SI_COUNT = 5;

    typedef enum logic [3:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_ST_RD,
        PH_ST_WR,
        PH_IGNORE,
        PH_REJECT
    } phase_e;

    typedef struct packed {
        logic       set_wel;
        logic       clr_wel;
        logic       buf_clr;
        logic       buf_we;
        logic [7:0] buf_data;
    } store_req_t;

    function automatic logic [7:0] pack_status(logic pe, logic [1:0] user,
                                               logic wel, logic busy);
        return {pe, 3'b000, user, wel, busy};
    endfunction

    function automatic logic op_ok_when_busy(logic [7:0] op);
        return op == OP_STAT_READ;
    endfunction

endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
    parameter int WIDTH = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/spim_store.sv
module spim_store import spim_pkg::*; #(
    parameter int DEPTH = 64,
    parameter int PAGE = 8,
    parameter int BUSY_CYCLES = 2000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int GW = AW - PW
) (
    input  logic          clk,
    input  logic          rst,
    input  store_req_t    req,
    input  logic [PW-1:0] buf_idx,
    input  logic [AW-1:0] rd_addr,
    input  logic          commit_mem,
    input  logic [GW-1:0] page_sel,
    input  logic          commit_stat,
    input  logic [7:0]    stat_val,
    output logic [7:0]    rd_data,
    output logic [7:0]    status,
    output logic          wel,
    output logic          pe,
    output logic          busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [7:0]    mem    [DEPTH];
    logic [7:0]    pbuf   [PAGE];
    logic [PAGE-1:0] pvalid;
    logic [1:0]    user_bits;
    logic [BW-1:0] busy_cnt;
    logic          commit_any;

    assign commit_any = commit_mem | commit_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
            pvalid    <= '0;
            wel       <= 1'b0;
            pe        <= 1'b0;
            user_bits <= '0;
            busy_cnt  <= '0;
        end else begin
            if (commit_mem) begin
                for (int i = 0; i < PAGE; i++)
                    if (pvalid[i]) mem[{page_sel, PW'(i)}] <= pbuf[i];
            end
            if (req.buf_clr) pvalid <= '0;
            else if (req.buf_we) begin
                pbuf[buf_idx]   <= req.buf_data;
                pvalid[buf_idx] <= 1'b1;
            end
            if (commit_any)       wel <= 1'b0;
            else if (req.set_wel) wel <= 1'b1;
            else if (req.clr_wel) wel <= 1'b0;
            if (commit_stat) begin
                pe        <= stat_val[7];
                user_bits <= stat_val[3:2];
            end
            if (commit_any)          busy_cnt <= BW'(BUSY_CYCLES);
            else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign busy    = busy_cnt != 0;
    assign rd_data = mem[rd_addr];
    assign status  = pack_status(pe, user_bits, wel, busy);

    // R6: the front end only commits while the latch is set
    p_commit_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
        commit_any |-> wel);
    // R7: a commit starts the busy window
    p_commit_sets_busy_r7: assert property (@(posedge clk) disable iff (rst)
        commit_any |=> busy);
    // R7: a commit drops the latch
    p_commit_drops_wel_r7: assert property (@(posedge clk) disable iff (rst)
        commit_any |=> !wel);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave import spim_pkg::*; #(
    parameter int DEPTH = 64,
    parameter int PAGE = 8,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic sclk,
    input  logic sdi,
    input  logic pause_n,
    input  logic prot_n,
    output logic sdo,
    output logic sdo_oe
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam int GW = AW - PW;
    localparam logic [SI_COUNT-1:0] SYNC_RST = 5'b11100;

    logic [SI_COUNT-1:0] raw, lvl, rise, fall;
    assign raw = {pause_n, prot_n, sel_n, sclk, sdi};

    spim_sync #(.WIDTH(SI_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(lvl), .rise(rise), .fall(fall)
    );

    logic sdi_q, sclk_q, sel_q, prot_q;
    logic sclk_rise, sclk_fall, sel_rise, sel_fall, pause_rise, pause_fall;
    assign sdi_q      = lvl[SI_DATA];
    assign sclk_q     = lvl[SI_CLK];
    assign sel_q      = lvl[SI_SEL];
    assign prot_q     = lvl[SI_PROT];
    assign sclk_rise  = rise[SI_CLK];
    assign sclk_fall  = fall[SI_CLK];
    assign sel_rise   = rise[SI_SEL];
    assign sel_fall   = fall[SI_SEL];
    assign pause_rise = rise[SI_PAUSE];
    assign pause_fall = fall[SI_PAUSE];

    phase_e        phase;
    logic [2:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic          out_bit, tx_active, paused;
    logic          rd_op, stat_op, have_data, wsr_abort;
    logic [7:0]    addr_hi, stat_val;
    logic [AW-1:0] ptr, rd_addr;
    logic [PW-1:0] buf_idx;
    store_req_t    req;

    logic [7:0]    rd_data, status;
    logic          wel, pe, busy, blocked;
    logic          commit_mem, commit_stat;
    logic [7:0]    new_byte;
    logic          byte_done;

    assign new_byte  = {rx_sh, sdi_q};
    assign byte_done = sclk_rise && !paused && !sel_q && bit_cnt == 3'd7
                       && phase != PH_REJECT;
    assign blocked   = pe && !prot_q;
    assign rd_addr   = (phase == PH_ADDR_LO) ? AW'({addr_hi, new_byte}) : ptr;

    assign commit_mem  = sel_rise && phase == PH_WR_DATA && have_data
                         && bit_cnt == 3'd0 && wel && !busy;
    assign commit_stat = sel_rise && stat_op && have_data && bit_cnt == 3'd0
                         && wel && !busy && !wsr_abort && !blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_OPCODE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            out_bit   <= 1'b0;
            tx_active <= 1'b0;
            paused    <= 1'b0;
            rd_op     <= 1'b0;
            stat_op   <= 1'b0;
            have_data <= 1'b0;
            wsr_abort <= 1'b0;
            addr_hi   <= '0;
            stat_val  <= '0;
            ptr       <= '0;
            buf_idx   <= '0;
            req       <= '0;
        end else begin
            req         <= '0;
            req.buf_clr <= sel_fall;
            if (sel_fall) begin
                phase     <= PH_OPCODE;
                bit_cnt   <= '0;
                paused    <= 1'b0;
                tx_active <= 1'b0;
                stat_op   <= 1'b0;
                have_data <= 1'b0;
                wsr_abort <= 1'b0;
            end else if (sel_q) begin
                phase     <= PH_OPCODE;
                paused    <= 1'b0;
                tx_active <= 1'b0;
                stat_op   <= 1'b0;
            end else begin
                if (!sclk_q && pause_fall)      paused <= 1'b1;
                else if (!sclk_q && pause_rise) paused <= 1'b0;
                if (stat_op && blocked) wsr_abort <= 1'b1;

                if (sclk_rise && !paused && phase != PH_REJECT) begin
                    if (bit_cnt != 3'd7) begin
                        rx_sh   <= new_byte[6:0];
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        bit_cnt <= '0;
                        unique case (phase)
                            PH_OPCODE: begin
                                if (busy && !op_ok_when_busy(new_byte)) phase <= PH_REJECT;
                                else begin
                                    case (new_byte)
                                        OP_WR_ENABLE: begin
                                            req.set_wel <= 1'b1;
                                            phase <= PH_IGNORE;
                                        end
                                        OP_WR_DISABLE: begin
                                            req.clr_wel <= 1'b1;
                                            phase <= PH_IGNORE;
                                        end
                                        OP_STAT_READ: begin
                                            tx_sh     <= status;
                                            tx_active <= 1'b1;
                                            phase     <= PH_ST_RD;
                                        end
                                        OP_STAT_WRITE: begin
                                            stat_op <= 1'b1;
                                            phase   <= PH_ST_WR;
                                        end
                                        OP_READ: begin
                                            rd_op <= 1'b1;
                                            phase <= PH_ADDR_HI;
                                        end
                                        OP_WRITE: begin
                                            rd_op <= 1'b0;
                                            phase <= PH_ADDR_HI;
                                        end
                                        default: phase <= PH_REJECT;
                                    endcase
                                end
                            end
                            PH_ADDR_HI: begin
                                addr_hi <= new_byte;
                                phase   <= PH_ADDR_LO;
                            end
                            PH_ADDR_LO: begin
                                if (rd_op) begin
                                    tx_sh     <= rd_data;
                                    tx_active <= 1'b1;
                                    ptr       <= rd_addr + 1'b1;
                                    phase     <= PH_RD_DATA;
                                end else begin
                                    ptr   <= rd_addr;
                                    phase <= PH_WR_DATA;
                                end
                            end
                            PH_RD_DATA: begin
                                tx_sh <= rd_data;
                                ptr   <= ptr + 1'b1;
                            end
                            PH_WR_DATA: begin
                                req.buf_we   <= 1'b1;
                                req.buf_data <= new_byte;
                                buf_idx      <= ptr[PW-1:0];
                                ptr[PW-1:0]  <= ptr[PW-1:0] + 1'b1;
                                have_data    <= 1'b1;
                            end
                            PH_ST_RD: tx_sh <= status;
                            PH_ST_WR: begin
                                stat_val  <= new_byte;
                                have_data <= 1'b1;
                                phase     <= PH_IGNORE;
                            end
                            PH_IGNORE, PH_REJECT: ;
                            default: ;
                        endcase
                    end
                end else if (sclk_fall && !paused) begin
                    out_bit <= tx_sh[7];
                    tx_sh   <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign sdo    = out_bit;
    assign sdo_oe = !sel_q && !paused && tx_active;

    spim_store #(.DEPTH(DEPTH), .PAGE(PAGE), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk(clk), .rst(rst), .req(req), .buf_idx(buf_idx), .rd_addr(rd_addr),
        .commit_mem(commit_mem), .page_sel(ptr[AW-1:PW]),
        .commit_stat(commit_stat), .stat_val(stat_val),
        .rd_data(rd_data), .status(status), .wel(wel), .pe(pe), .busy(busy)
    );

    // R8: a rejected command never drives the output
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_REJECT |-> !sdo_oe);
    // R9: a frozen transfer keeps its bit position
    p_pause_keeps_count_r9: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> $stable(bit_cnt));
    // R11: once a status write is spoiled it stays spoiled until reselect
    p_abort_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (wsr_abort && !sel_fall) |=> wsr_abort);
endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
    localparam int HALF = 8;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, pause_n = 1'b1, prot_n = 1'b1;
    logic sdo, sdo_oe;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_mem_slave #(.DEPTH(64), .PAGE(8), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .pause_n(pause_n), .prot_n(prot_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int hi, input int lo,
                         inout logic [7:0] rx, inout logic oe_seen);
        for (int i = hi; i >= lo; i--) begin
            sdi = tx[i];
            wait_clk(HALF);
            rx[i] = sdo;
            if (sdo_oe) oe_seen = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
        logic [7:0] r = '0;
        logic o = 1'b0;
        xbits(tx, 7, 0, r, o);
        rx = r;
        oe_seen = o;
    endtask

    task automatic sel_on();
        sel_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic sel_off();
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        logic o;
        sel_on();
        xbyte(op, r, o);
        sel_off();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        logic o;
        sel_on();
        xbyte(8'h05, r, o);
        xbyte(8'h00, s, o);
        sel_off();
    endtask

    task automatic rd2(input logic [15:0] a, output logic [7:0] b0,
                       output logic [7:0] b1, output logic oe);
        logic [7:0] r;
        logic o;
        sel_on();
        xbyte(8'h03, r, o);
        xbyte(a[15:8], r, o);
        xbyte(a[7:0], r, o);
        xbyte(8'h00, b0, oe);
        xbyte(8'h00, b1, o);
        oe = oe | o;
        sel_off();
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [7:0] r;
        logic o;
        sel_on();
        xbyte(8'h01, r, o);
        xbyte(v, r, o);
        sel_off();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R2 reset oe", {31'b0, sdo_oe}, 32'h0);
        rd_status(s);
        chk("R4 reset status", {24'b0, s}, 32'h00);
    endtask

    task automatic t_deselected();
        logic [7:0] s;
        bit oe_any = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sdi = i[0];
            sclk = ~sclk;
            wait_clk(HALF);
            if (sdo_oe) oe_any = 1'b1;
        end
        sclk = 1'b0;
        chk("R2 oe while deselected", {31'b0, oe_any}, 32'h0);
        rd_status(s);
        chk("R2 status after idle clocks", {24'b0, s}, 32'h00);
    endtask

    task automatic t_latch();
        logic [7:0] s;
        cmd1(8'h06);
        rd_status(s);
        chk("R3 set latch", {24'b0, s}, 32'h02);
        cmd1(8'h04);
        rd_status(s);
        chk("R3 clear latch", {24'b0, s}, 32'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] r, b0, b1, s;
        logic o;
        // no latch: dropped
        sel_on();
        xbyte(8'h02, r, o); xbyte(8'h00, r, o); xbyte(8'h05, r, o); xbyte(8'hA5, r, o);
        sel_off();
        rd2(16'h0005, b0, b1, o);
        chk("R6 write without latch", {24'b0, b0}, 32'h00);
        // latched write with in-page wrap
        cmd1(8'h06);
        sel_on();
        xbyte(8'h02, r, o); xbyte(8'h00, r, o); xbyte(8'h06, r, o);
        xbyte(8'h11, r, o); xbyte(8'h22, r, o); xbyte(8'h33, r, o);
        sel_off();
        rd_status(s);
        chk("R7 busy set, latch cleared", {24'b0, s}, 32'h01);
        rd2(16'h0006, b0, b1, o);
        chk("R7 read rejected while busy", {31'b0, o}, 32'h0);
        wait_clk(BUSY + 100);
        rd2(16'h0006, b0, b1, o);
        chk("R1 R5 read addr 6", {24'b0, b0}, 32'h11);
        chk("R5 sequential addr 7", {24'b0, b1}, 32'h22);
        chk("R5 oe during read", {31'b0, o}, 32'h1);
        rd2(16'h0000, b0, b1, o);
        chk("R6 in-page wrap to 0", {24'b0, b0}, 32'h33);
        rd2(16'h003F, b0, b1, o);
        chk("R5 last address", {24'b0, b0}, 32'h00);
        chk("R5 wrap to address 0", {24'b0, b1}, 32'h33);
        rd2(16'h1206, b0, b1, o);
        chk("R5 address modulo depth", {24'b0, b0}, 32'h11);
        rd_status(s);
        chk("R7 idle after busy", {24'b0, s}, 32'h00);
    endtask

    task automatic t_partial();
        logic [7:0] r, b0, b1, s;
        logic o;
        cmd1(8'h06);
        sel_on();
        xbyte(8'h02, r, o); xbyte(8'h00, r, o); xbyte(8'h0A, r, o); xbyte(8'h5A, r, o);
        xbits(8'hFF, 7, 5, r, o);
        sel_off();
        rd2(16'h000A, b0, b1, o);
        chk("R6 partial byte drops write", {24'b0, b0}, 32'h00);
        rd_status(s);
        chk("R6 latch kept after drop", {24'b0, s}, 32'h02);
        cmd1(8'h04);
    endtask

    task automatic t_invalid();
        logic [7:0] r, s;
        logic o;
        sel_on();
        xbyte(8'hFF, r, o);
        xbyte(8'h05, r, o);
        xbyte(8'h00, r, o);
        sel_off();
        chk("R8 no drive after bad op", {31'b0, o}, 32'h0);
        sel_on();
        xbyte(8'hA5, r, o);
        xbyte(8'h06, r, o);
        sel_off();
        rd_status(s);
        chk("R8 later bytes ignored", {24'b0, s}, 32'h00);
    endtask

    task automatic t_pause();
        logic [7:0] r, b1;
        logic [7:0] b0 = '0;
        logic o = 1'b0;
        logic oe_hold = 1'b0;
        sel_on();
        xbyte(8'h03, r, o); xbyte(8'h00, r, o); xbyte(8'h06, r, o);
        xbits(8'h00, 7, 4, b0, o);
        pause_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            if (sdo_oe) oe_hold = 1'b1;
            sclk = 1'b0;
            wait_clk(HALF);
            if (sdo_oe) oe_hold = 1'b1;
        end
        pause_n = 1'b1;
        xbits(8'h00, 3, 0, b0, o);
        xbyte(8'h00, b1, o);
        sel_off();
        chk("R9 no drive while paused", {31'b0, oe_hold}, 32'h0);
        chk("R9 byte across pause", {24'b0, b0}, 32'h11);
        chk("R9 next byte aligned", {24'b0, b1}, 32'h22);
    endtask

    task automatic t_protect();
        logic [7:0] r, s;
        logic o;
        cmd1(8'h06);
        wr_stat(8'h8C);
        wait_clk(BUSY + 100);
        rd_status(s);
        chk("R1 R4 status write lands", {24'b0, s}, 32'h8C);
        prot_n = 1'b0;
        cmd1(8'h06);
        wr_stat(8'h00);
        rd_status(s);
        chk("R10 pin low blocks", {24'b0, s}, 32'h8E);
        prot_n = 1'b1;
        sel_on();
        xbyte(8'h01, r, o);
        xbits(8'h04, 7, 4, r, o);
        prot_n = 1'b0;
        wait_clk(HALF);
        prot_n = 1'b1;
        wait_clk(HALF);
        xbits(8'h04, 3, 0, r, o);
        sel_off();
        rd_status(s);
        chk("R11 glitch aborts write", {24'b0, s}, 32'h8E);
        wr_stat(8'h04);
        rd_status(s);
        chk("R7 R10 pin high allows", {24'b0, s}, 32'h05);
        wait_clk(BUSY + 100);
        prot_n = 1'b0;
        cmd1(8'h06);
        wr_stat(8'h08);
        wait_clk(BUSY + 100);
        rd_status(s);
        chk("R10 pin ignored when enable clear", {24'b0, s}, 32'h08);
        prot_n = 1'b1;
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_deselected();
        t_latch();
        t_write_read();
        t_partial();
        t_invalid();
        t_pause();
        t_protect();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule